// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block models the management register set of a basic 10/100 Ethernet PHY as seen by a station manager. A parallel request port stands in for the serial management frame engine. Each request carries a PHY address, a 5-bit register number, a write flag and 16-bit write data. A read answers with one response word on the following cycle. A write changes state silently and produces no response.

The block holds a control register, a status register, two fixed identifier words, an advertisement register and a link-partner ability register. The PHY address it answers to comes from a strap input. A link input rewrites the link bits of the status register and the contents of the partner register. Setting bit 15 of the control register in a write reloads every default value. The current link state then applies again at once.

Top module: `mii_mgmt_regs`

## Requirements
- R1: A read whose PHY address differs from `cfg_phy_addr` returns 0xFFFF.
- R2: After reset, register 0 (control) reads 0x3100: bit 13 (100 Mb/s), bit 12 (autonegotiation enable) and bit 8 (full duplex).
- R3: Register 1 (status) reads 0x7848 while the link is down and 0x786C while it is up. The set bits are 14, 13, 12 and 11 (100TX/10T full and half duplex), 6 (preamble suppression) and 3 (autonegotiation ability). Bit 5 (autonegotiation complete) and bit 2 (link) follow the link.
- R4: After reset, register 4 (advertisement) reads 0x01E1: bits 8, 7, 6 and 5 plus selector bit 0. A write to it is stored and read back.
- R5: Register 5 (partner ability) reads 0x0080 while the link is down and 0x01E0 while it is up.
- R6: A change on `link_up` is visible to a read issued in the cycle after the clock edge that follows the change.
- R7: A write to register 0 with bit 15 set returns control to 0x3100 and advertisement to 0x01E1. The status and partner registers keep reflecting the current link. Bit 15 always reads 0.
- R8: A write to register 0 with bit 15 clear stores bits 14..0 of the write data.
- R9: Register 2 reads the parameter `ID_HI` (default 0x0141) and register 3 reads `ID_LO` (default 0x0C20).
- R10: Writes to registers 1, 2, 3 and 5 leave their read values unchanged.
- R11: Registers 6 to 31 read 0x0000, and writes to them have no effect.
- R12: A write whose PHY address differs from `cfg_phy_addr` changes no register.
- R13: `rsp_valid` is high exactly in the cycle after a read request. It carries the read data in `rsp_rdata`, and a write request never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_phy_addr | input | 5 | PHY address this block answers to |
| link_up | input | 1 | Link state, synchronous to clk |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 16 | Read response data |

## Verification
The assertions assume `link_up` and all request fields are synchronous to `clk`. They also assume the request fields matter only in a cycle where `req_valid` is high. The address comparison uses `cfg_phy_addr` as sampled in the request cycle, so the strap may change between requests but is treated as stable within one. The stimulus drives every input on the falling edge and raises `req_valid` for a single cycle per request. It changes the strap and the link only while no request is pending.

// File: rtl/mii_mgmt_pkg.sv
// Package: shared widths, register indices, bit positions and derived
// default words for the PHY management register model.
// Assumes the standard 16-bit management register width.
package mii_mgmt_pkg;
    localparam int DATA_W = 16;
    typedef logic [DATA_W-1:0] word_t;

    // Register numbers
    localparam int REG_CTRL    = 0;
    localparam int REG_STAT    = 1;
    localparam int REG_ID_HI   = 2;
    localparam int REG_ID_LO   = 3;
    localparam int REG_ADV     = 4;
    localparam int REG_PARTNER = 5;

    // Control bits
    localparam int CTL_RST_B   = 15;
    localparam int CTL_SPEED_B = 13;
    localparam int CTL_ANEN_B  = 12;
    localparam int CTL_FDX_B   = 8;

    // Status bits
    localparam int ST_TXFD_B  = 14;
    localparam int ST_TXHD_B  = 13;
    localparam int ST_10FD_B  = 12;
    localparam int ST_10HD_B  = 11;
    localparam int ST_PRE_B   = 6;
    localparam int ST_ANC_B   = 5;
    localparam int ST_ANA_B   = 3;
    localparam int ST_LINK_B  = 2;

    // Ability bits shared by advertisement and partner registers
    localparam int AB_TXFD_B = 8;
    localparam int AB_TXHD_B = 7;
    localparam int AB_10FD_B = 6;
    localparam int AB_10HD_B = 5;
    localparam int AB_SEL_B  = 0;

    localparam word_t CTRL_DEF = word_t'((1 << CTL_SPEED_B) | (1 << CTL_ANEN_B) | (1 << CTL_FDX_B));
    localparam word_t STAT_BASE = word_t'((1 << ST_TXFD_B) | (1 << ST_TXHD_B) | (1 << ST_10FD_B)
                                        | (1 << ST_10HD_B) | (1 << ST_PRE_B) | (1 << ST_ANA_B));
    localparam word_t STAT_LINK = word_t'((1 << ST_ANC_B) | (1 << ST_LINK_B));
    localparam word_t ADV_DEF = word_t'((1 << AB_TXFD_B) | (1 << AB_TXHD_B) | (1 << AB_10FD_B)
                                      | (1 << AB_10HD_B) | (1 << AB_SEL_B));
    localparam word_t PART_DOWN = word_t'(1 << AB_TXHD_B);
    localparam word_t PART_UP   = word_t'((1 << AB_TXHD_B) | (1 << AB_TXFD_B)
                                        | (1 << AB_10FD_B) | (1 << AB_10HD_B));
endpackage

// File: rtl/mii_ctrl_bank.sv
// Writable register bank: control and advertisement words.
// Assumes wr_en is already qualified by PHY address match. A control
// write with the reset bit reloads both words; the reset bit is never stored.
module mii_ctrl_bank
    import mii_mgmt_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_reg,
    input  word_t             wr_data,
    output word_t             ctrl_word,
    output word_t             adv_word
);
    localparam logic [REG_AW-1:0] IDX_CTRL = REG_AW'(REG_CTRL);
    localparam logic [REG_AW-1:0] IDX_ADV  = REG_AW'(REG_ADV);
    localparam word_t RST_MASK = word_t'(1 << CTL_RST_B);

    word_t ctrl_q, adv_q;

    // Update control/advertisement on qualified writes, reload on soft reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_DEF;
            adv_q  <= ADV_DEF;
        end else if (wr_en) begin
            if (wr_reg == IDX_CTRL) begin
                if (wr_data[CTL_RST_B]) begin
                    ctrl_q <= CTRL_DEF;
                    adv_q  <= ADV_DEF;
                end else begin
                    ctrl_q <= wr_data & ~RST_MASK;
                end
            end else if (wr_reg == IDX_ADV) begin
                adv_q <= wr_data;
            end
        end
    end

    assign ctrl_word = ctrl_q;
    assign adv_word  = adv_q;
endmodule

// File: rtl/mii_link_tracker.sv
// Link tracker: registers the link input and forms the status and
// partner-ability words from it. Assumes link_up is synchronous to clk.
// These words are read-only, so a soft reset needs no reload here.
module mii_link_tracker
    import mii_mgmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  link_up,
    output word_t status_word,
    output word_t partner_word
);
    logic link_q;

    // Capture link state one edge after it changes
    always_ff @(posedge clk) begin
        if (!rst_n) link_q <= 1'b0;
        else        link_q <= link_up;
    end

    // Form status and partner words from the captured link
    always_comb begin
        status_word  = link_q ? (STAT_BASE | STAT_LINK) : STAT_BASE;
        partner_word = link_q ? PART_UP : PART_DOWN;
    end
endmodule

// File: rtl/mii_read_path.sv
// Read path: selects the addressed word and registers the response.
// Assumes one request per cycle; writes produce no response.
module mii_read_path
    import mii_mgmt_pkg::*;
#(
    parameter int    REG_AW = 5,
    parameter word_t ID_HI  = 16'h0141,
    parameter word_t ID_LO  = 16'h0C20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              addr_hit,
    input  logic [REG_AW-1:0] rd_reg,
    input  word_t             ctrl_word,
    input  word_t             status_word,
    input  word_t             adv_word,
    input  word_t             partner_word,
    output logic              rsp_valid,
    output word_t             rsp_rdata
);
    localparam logic [REG_AW-1:0] IDX_CTRL    = REG_AW'(REG_CTRL);
    localparam logic [REG_AW-1:0] IDX_STAT    = REG_AW'(REG_STAT);
    localparam logic [REG_AW-1:0] IDX_ID_HI   = REG_AW'(REG_ID_HI);
    localparam logic [REG_AW-1:0] IDX_ID_LO   = REG_AW'(REG_ID_LO);
    localparam logic [REG_AW-1:0] IDX_ADV     = REG_AW'(REG_ADV);
    localparam logic [REG_AW-1:0] IDX_PARTNER = REG_AW'(REG_PARTNER);

    word_t sel_word;

    // Choose the addressed word; foreign PHY reads float high
    always_comb begin
        if (!addr_hit) begin
            sel_word = '1;
        end else begin
            unique case (rd_reg)
                IDX_CTRL:    sel_word = ctrl_word;
                IDX_STAT:    sel_word = status_word;
                IDX_ID_HI:   sel_word = ID_HI;
                IDX_ID_LO:   sel_word = ID_LO;
                IDX_ADV:     sel_word = adv_word;
                IDX_PARTNER: sel_word = partner_word;
                default:     sel_word = '0;
            endcase
        end
    end

    // Register the response one cycle after the read request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) rsp_rdata <= sel_word;
        end
    end
endmodule

// File: rtl/mii_mgmt_regs.sv
// Top: PHY management register file with a parallel request port.
// Assumes a single-cycle req_valid strobe per request and synchronous
// inputs. Qualifies requests by PHY address and wires the sub-blocks.
module mii_mgmt_regs
    import mii_mgmt_pkg::*;
#(
    parameter int    PHY_AW = 5,
    parameter int    REG_AW = 5,
    parameter word_t ID_HI  = 16'h0141,
    parameter word_t ID_LO  = 16'h0C20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHY_AW-1:0] cfg_phy_addr,
    input  logic              link_up,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [PHY_AW-1:0] req_phy,
    input  logic [REG_AW-1:0] req_reg,
    input  logic [15:0]       req_wdata,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata
);
    logic  addr_hit, wr_en, rd_en;
    word_t ctrl_word, adv_word, status_word, partner_word;

    // Qualify requests by address and direction
    always_comb begin
        addr_hit = (req_phy == cfg_phy_addr);
        wr_en    = req_valid && req_write && addr_hit;
        rd_en    = req_valid && !req_write;
    end

    mii_ctrl_bank #(.REG_AW(REG_AW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_reg    (req_reg),
        .wr_data   (req_wdata),
        .ctrl_word (ctrl_word),
        .adv_word  (adv_word)
    );

    mii_link_tracker u_link (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_up      (link_up),
        .status_word  (status_word),
        .partner_word (partner_word)
    );

    mii_read_path #(.REG_AW(REG_AW), .ID_HI(ID_HI), .ID_LO(ID_LO)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .addr_hit     (addr_hit),
        .rd_reg       (req_reg),
        .ctrl_word    (ctrl_word),
        .status_word  (status_word),
        .adv_word     (adv_word),
        .partner_word (partner_word),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata)
    );
endmodule

// File: rtl/mii_mgmt_regs_chk.sv
// Checker: temporal properties of the management register file, bound
// to the top. Assumes synchronous inputs and single-cycle requests.
module mii_mgmt_regs_chk
    import mii_mgmt_pkg::*;
#(
    parameter int    PHY_AW = 5,
    parameter int    REG_AW = 5,
    parameter word_t ID_HI  = 16'h0141
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PHY_AW-1:0] cfg_phy_addr,
    input logic              req_valid,
    input logic              req_write,
    input logic [PHY_AW-1:0] req_phy,
    input logic [REG_AW-1:0] req_reg,
    input logic [15:0]       req_wdata,
    input logic              rsp_valid,
    input logic [15:0]       rsp_rdata,
    input word_t             ctrl_word,
    input word_t             adv_word
);
    logic hit_rd, hit_wr;
    assign hit_rd = req_valid && !req_write && (req_phy == cfg_phy_addr);
    assign hit_wr = req_valid && req_write && (req_phy == cfg_phy_addr);

    p_foreign_ffff_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_phy != cfg_phy_addr) |=> (rsp_valid && rsp_rdata == 16'hFFFF));

    p_link_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_rd && req_reg == REG_AW'(REG_STAT)) |=> (rsp_rdata[ST_LINK_B] == rsp_rdata[ST_ANC_B]));

    p_rst_bit_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_rd && req_reg == REG_AW'(REG_CTRL)) |=> !rsp_rdata[CTL_RST_B]);

    p_soft_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && req_reg == REG_AW'(REG_CTRL) && req_wdata[CTL_RST_B])
        |=> (ctrl_word == CTRL_DEF && adv_word == ADV_DEF));

    p_id_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_rd && req_reg == REG_AW'(REG_ID_HI)) |=> (rsp_rdata == ID_HI));

    p_ctrl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_wr && req_reg == REG_AW'(REG_CTRL)) |=> $stable(ctrl_word));

    p_read_answers_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    p_write_silent_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind mii_mgmt_regs mii_mgmt_regs_chk #(
    .PHY_AW (PHY_AW),
    .REG_AW (REG_AW),
    .ID_HI  (ID_HI)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_phy_addr (cfg_phy_addr),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_phy      (req_phy),
    .req_reg      (req_reg),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .ctrl_word    (ctrl_word),
    .adv_word     (adv_word)
);

// File: tb/mii_mgmt_regs_test.sv
// Scoreboard bench: read tasks push expected words, a monitor pops and
// compares them against each response.
module mii_mgmt_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_phy_addr = 5'd3;
    logic        link_up = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    logic [15:0] exp_q[$];
    string tag_q[$];

    mii_mgmt_regs uut (
        .clk(clk), .rst_n(rst_n), .cfg_phy_addr(cfg_phy_addr), .link_up(link_up),
        .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
        .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    always #4 clk = ~clk;

    task automatic check_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_phy = phy; req_reg = rg; req_wdata = '0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_phy = phy; req_reg = rg; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Monitor: compare every response against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R13 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                check_eq(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check_eq("R13 reset rsp_valid", {15'd0, rsp_valid}, 16'h0000);

        // Defaults with link down
        do_read(5'd3, 5'd0, 16'h3100, "R2 control default");
        do_read(5'd3, 5'd1, 16'h7848, "R3 status link down");
        do_read(5'd3, 5'd4, 16'h01E1, "R4 adv default");
        do_read(5'd3, 5'd5, 16'h0080, "R5 partner link down");
        do_read(5'd3, 5'd2, 16'h0141, "R9 id hi");
        do_read(5'd3, 5'd3, 16'h0C20, "R9 id lo");
        do_read(5'd3, 5'd7, 16'h0000, "R11 unimpl reg7");
        do_read(5'd3, 5'd31, 16'h0000, "R11 unimpl reg31");
        do_read(5'd4, 5'd0, 16'hFFFF, "R1 foreign phy");

        // Link up: visible one edge later
        @(negedge clk) link_up = 1'b1;
        do_read(5'd3, 5'd1, 16'h786C, "R6 R3 status link up");
        do_read(5'd3, 5'd5, 16'h01E0, "R5 partner link up");

        // Writable registers
        do_write(5'd3, 5'd4, 16'h0021);
        do_read(5'd3, 5'd4, 16'h0021, "R4 adv write");
        do_write(5'd3, 5'd0, 16'h1000);
        do_read(5'd3, 5'd0, 16'h1000, "R8 control write");
        do_write(5'd3, 5'd0, 16'h7FFF);
        do_read(5'd3, 5'd0, 16'h7FFF, "R8 control write all low bits");

        // Soft reset
        do_write(5'd3, 5'd0, 16'h8000);
        do_read(5'd3, 5'd0, 16'h3100, "R7 control reloaded");
        do_read(5'd3, 5'd4, 16'h01E1, "R7 adv reloaded");
        do_read(5'd3, 5'd1, 16'h786C, "R7 link reapplied");
        do_write(5'd3, 5'd0, 16'hFFFF);
        do_read(5'd3, 5'd0, 16'h3100, "R7 reset bit reads zero");

        // Read-only and unimplemented writes
        do_write(5'd3, 5'd1, 16'h0000);
        do_write(5'd3, 5'd2, 16'h0000);
        do_write(5'd3, 5'd3, 16'hFFFF);
        do_write(5'd3, 5'd5, 16'h0000);
        do_read(5'd3, 5'd1, 16'h786C, "R10 status unchanged");
        do_read(5'd3, 5'd2, 16'h0141, "R10 id hi unchanged");
        do_read(5'd3, 5'd3, 16'h0C20, "R10 id lo unchanged");
        do_read(5'd3, 5'd5, 16'h01E0, "R10 partner unchanged");
        do_write(5'd3, 5'd9, 16'hFFFF);
        do_read(5'd3, 5'd9, 16'h0000, "R11 unimpl write ignored");

        // Foreign address write
        do_write(5'd6, 5'd0, 16'h0000);
        do_write(5'd6, 5'd4, 16'h0000);
        do_read(5'd3, 5'd0, 16'h3100, "R12 control untouched");
        do_read(5'd3, 5'd4, 16'h01E1, "R12 adv untouched");

        // Write produces no response
        do_write(5'd3, 5'd4, 16'h01E1);
        @(negedge clk);
        check_eq("R13 write no response", {15'd0, rsp_valid}, 16'h0000);

        // Link down again
        @(negedge clk) link_up = 1'b0;
        do_read(5'd3, 5'd1, 16'h7848, "R6 R3 status link down again");
        do_read(5'd3, 5'd5, 16'h0080, "R5 partner down again");

        // New strap address
        @(negedge clk) cfg_phy_addr = 5'd7;
        do_read(5'd7, 5'd0, 16'h3100, "R1 new address answers");
        do_read(5'd3, 5'd0, 16'hFFFF, "R1 old address floats");

        repeat (4) @(negedge clk);
        check_eq("R13 scoreboard drained", 16'(exp_q.size()), 16'h0000);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule